// File: doc/BRIEF.md
# Exception Status and Cause Controller

This block holds the two exception-control registers of a small 32-bit processor core. The Status register carries one enable bit for each of five interrupt levels and a three-entry stack of mode pairs, where each pair is a user/kernel flag and an interrupt-enable flag. The Cause register records which interrupt levels are waiting for service and a five-bit code naming the reason for the most recent exception.

The pipeline raises an exception strobe, with a code, when it takes a trap or an interrupt. The block then pushes the mode stack so that the core enters kernel mode with interrupts off, and it keeps the interrupted context in the deeper entries. A return strobe pops the stack and restores that context. Software reads and writes both registers through a single move-to/move-from port that uses a one-bit register select.

The block also drives two outputs: a user-mode flag and an interrupt request. The request is high when the current enable bit is on and some waiting level is also unmasked. The core is expected to answer that request with an exception strobe.

Top module: `exc_ctl`

## Requirements
- R1: After synchronous reset, Status and Cause both read 0. This means kernel mode in every pair, interrupts disabled, all levels masked and nothing pending. `user_mode` and `irq_take` are 0.
- R2: A move-to write with select 0 loads the level mask from data bits 12:8 and the mode stack from bits 5:0. Status reads back only those bits, and all other bits read 0. Stack bit layout: bit 0 current enable, bit 1 current user flag, bits 3:2 previous pair, bits 5:4 old pair.
- R3: A move-to write with select 1 loads the pending bits from data bits 12:8 and the exception code from bits 6:2. Cause reads back only those bits, and all other bits read 0. A request line that is high in the same cycle keeps its pending bit set.
- R4: An exception strobe shifts the stack left by two. Current goes to previous, previous goes to old, and the new current pair is 00. The strobe also loads the exception code into Cause bits 6:2 and leaves the pending bits alone.
- R5: A return strobe shifts the stack right by two. Previous goes to current, old goes to previous, and the old pair keeps its value. The mask, the pending bits and the code do not change.
- R6: A request line that is high at a clock edge sets its pending bit, with line i mapped to Cause bit 8+i. The bit stays set after the line falls, until a Cause write clears it.
- R7: `irq_take` is 1 exactly when the current enable bit is 1 and at least one level has both its pending bit and its mask bit set.
- R8: `user_mode` equals the current user flag, Status bit 1.
- R9: If the exception and return strobes arrive together, the exception wins. A move-to write in the same cycle as either strobe is dropped and changes no register.
- R10: `rd_data` shows Status when the select is 0 and Cause when the select is 1. It reflects register state at once, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 5 | Interrupt request lines, one per level |
| exc_req | input | 1 | Exception taken strobe |
| exc_code | input | 5 | Reason code recorded with the exception |
| eret_req | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | Move-to register write enable |
| reg_sel | input | 1 | Register select: 0 Status, 1 Cause |
| wr_data | input | 32 | Move-to write data |
| rd_data | output | 32 | Move-from read data |
| status_o | output | 32 | Status register contents |
| cause_o | output | 32 | Cause register contents |
| user_mode | output | 1 | Current pair user flag |
| irq_take | output | 1 | Interrupt should be taken |

## Verification
A wrong stack shift shows on `status_o` and `user_mode` in the cycle right after the strobe. It also shows on `irq_take` as soon as any unmasked level is pending, so the bench sweeps all 64 stack values through both push and pop. A lost or stuck pending bit changes `cause_o` one edge after the request line moves. Sweeping every mask/pending/enable combination exposes a wrong interrupt term on `irq_take` in the same cycle that the registers settle. A dropped-write or priority fault leaves a changed mask or code that can be read on the next cycle.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    localparam int XLEN     = 32;
    localparam int NUM_LVL  = 5;
    localparam int CODE_W   = 5;
    localparam int LVL_LSB  = 8;
    localparam int CODE_LSB = 2;
    localparam int STACK_W  = 6;

    typedef struct packed {
        logic ku;
        logic ie;
    } mode_pair_t;

    typedef struct packed {
        mode_pair_t old_p;
        mode_pair_t prev_p;
        mode_pair_t cur_p;
    } mode_stack_t;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_LOAD = 2'd3
    } stack_op_e;

    function automatic mode_stack_t stack_push(input mode_stack_t s);
        mode_stack_t r;
        r.old_p  = s.prev_p;
        r.prev_p = s.cur_p;
        r.cur_p  = '0;
        return r;
    endfunction

    function automatic mode_stack_t stack_pop(input mode_stack_t s);
        mode_stack_t r;
        r.old_p  = s.old_p;
        r.prev_p = s.old_p;
        r.cur_p  = s.prev_p;
        return r;
    endfunction

    function automatic logic [XLEN-1:0] pack_status(input logic [NUM_LVL-1:0] mask,
                                                    input mode_stack_t stk);
        logic [XLEN-1:0] w;
        w = '0;
        w[LVL_LSB +: NUM_LVL] = mask;
        w[STACK_W-1:0]        = stk;
        return w;
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(input logic [NUM_LVL-1:0] pend,
                                                   input logic [CODE_W-1:0] code);
        logic [XLEN-1:0] w;
        w = '0;
        w[LVL_LSB +: NUM_LVL]  = pend;
        w[CODE_LSB +: CODE_W]  = code;
        return w;
    endfunction

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
    import exc_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stack_op_e   op,
    input  mode_stack_t load_val,
    output mode_stack_t stk
);

    mode_stack_t stk_next;

    always_comb begin
        unique case (op)
            STK_PUSH: stk_next = stack_push(stk);
            STK_POP:  stk_next = stack_pop(stk);
            STK_LOAD: stk_next = load_val;
            default:  stk_next = stk;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stk <= '0;
        else     stk <= stk_next;
    end

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (op == STK_PUSH) |=> (stk[5:2] == $past(stk[3:0])) && (stk[1:0] == 2'b00)); // R4

    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (op == STK_POP) |=> (stk[3:0] == $past(stk[5:2])) && (stk[5:4] == $past(stk[5:4]))); // R5

    AST_HOLD_STACK: assert property (@(posedge clk) disable iff (rst)
        (op == STK_HOLD) |=> $stable(stk)); // R9

endmodule

// File: rtl/exc_pending_latch.sv
module exc_pending_latch #(
    parameter int NUM_LVL = exc_ctl_pkg::NUM_LVL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] irq_i,
    input  logic               load,
    input  logic [NUM_LVL-1:0] load_val,
    output logic [NUM_LVL-1:0] pend
);

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)           pend[g] <= 1'b0;
            else if (irq_i[g]) pend[g] <= 1'b1;
            else if (load)     pend[g] <= load_val[g];
        end
    end

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (irq_i != '0) |=> ((pend & $past(irq_i)) == $past(irq_i))); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> ((pend & $past(pend)) == $past(pend))); // R6

endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
    import exc_ctl_pkg::*;
#(
    parameter int NUM_LVL_P = NUM_LVL,
    parameter int CODE_W_P  = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LVL_P-1:0] irq_i,
    input  logic                 exc_req,
    input  logic [CODE_W_P-1:0]  exc_code,
    input  logic                 eret_req,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [XLEN-1:0]      wr_data,
    output logic [XLEN-1:0]      rd_data,
    output logic [XLEN-1:0]      status_o,
    output logic [XLEN-1:0]      cause_o,
    output logic                 user_mode,
    output logic                 irq_take
);

    logic                 wr_ok;
    logic                 status_wr;
    logic                 cause_wr;
    stack_op_e            stk_op;
    mode_stack_t          stk;
    logic [NUM_LVL_P-1:0] mask_q;
    logic [NUM_LVL_P-1:0] pend;
    logic [CODE_W_P-1:0]  code_q;

    assign wr_ok     = reg_wr && !exc_req && !eret_req;
    assign status_wr = wr_ok && !reg_sel;
    assign cause_wr  = wr_ok && reg_sel;

    always_comb begin
        if (exc_req)        stk_op = STK_PUSH;
        else if (eret_req)  stk_op = STK_POP;
        else if (status_wr) stk_op = STK_LOAD;
        else                stk_op = STK_HOLD;
    end

    exc_mode_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (stk_op),
        .load_val (mode_stack_t'(wr_data[STACK_W-1:0])),
        .stk      (stk)
    );

    exc_pending_latch #(.NUM_LVL(NUM_LVL_P)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .irq_i    (irq_i),
        .load     (cause_wr),
        .load_val (wr_data[LVL_LSB +: NUM_LVL_P]),
        .pend     (pend)
    );

    always_ff @(posedge clk) begin
        if (rst)            mask_q <= '0;
        else if (status_wr) mask_q <= wr_data[LVL_LSB +: NUM_LVL_P];
    end

    always_ff @(posedge clk) begin
        if (rst)           code_q <= '0;
        else if (exc_req)  code_q <= exc_code;
        else if (cause_wr) code_q <= wr_data[CODE_LSB +: CODE_W_P];
    end

    assign status_o  = pack_status(mask_q, stk);
    assign cause_o   = pack_cause(pend, code_q);
    assign rd_data   = reg_sel ? cause_o : status_o;
    assign user_mode = stk.cur_p.ku;
    assign irq_take  = stk.cur_p.ie && ((pend & mask_q) != '0);

    AST_EXC_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> !irq_take && !user_mode); // R4

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && !cause_wr) |=> $stable(code_q)); // R5

    AST_DROP_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (exc_req || eret_req)) |=> $stable(mask_q)); // R9

    AST_EXC_CODE: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> (code_q == $past(exc_code))); // R4

endmodule

// File: tb/test_exc_ctl.sv
module test_exc_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  irq_i;
    logic        exc_req;
    logic [4:0]  exc_code;
    logic        eret_req;
    logic        reg_wr;
    logic        reg_sel;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [31:0] status_o;
    logic [31:0] cause_o;
    logic        user_mode;
    logic        irq_take;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    exc_ctl i_exc_ctl (
        .clk(clk), .rst(rst), .irq_i(irq_i), .exc_req(exc_req), .exc_code(exc_code),
        .eret_req(eret_req), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
        .rd_data(rd_data), .status_o(status_o), .cause_o(cause_o),
        .user_mode(user_mode), .irq_take(irq_take)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0; exc_req = 0; eret_req = 0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr = 1; reg_sel = sel; wr_data = d;
        tick();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; irq_i = 0; exc_req = 0; exc_code = 0; eret_req = 0;
        reg_wr = 0; reg_sel = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 status", status_o, 0);
        check("R1 cause", cause_o, 0);
        check("R1 flags", {30'd0, user_mode, irq_take}, 0);

        // R2 / R3 field masks and R10 read select
        wr(0, 32'hFFFF_FFFF);
        check("R2 status all ones", status_o, 32'h0000_1F3F);
        reg_sel = 0; #1 check("R10 sel0", rd_data, 32'h0000_1F3F);
        wr(0, 32'h0);
        check("R2 status zero", status_o, 0);
        wr(1, 32'hFFFF_FFFF);
        check("R3 cause all ones", cause_o, 32'h0000_1F7C);
        reg_sel = 1; #1 check("R10 sel1", rd_data, 32'h0000_1F7C);
        wr(1, 32'h0);
        check("R3 cause zero", cause_o, 0);

        // R4 / R5 / R8 exhaustive stack sweep
        for (int s = 0; s < 64; s++) begin
            logic [5:0] v;
            v = 6'(s);
            wr(0, {19'd0, 5'h15, 2'b00, v});
            check("R8 user flag", {31'd0, user_mode}, {31'd0, v[1]});
            exc_req = 1; exc_code = 5'(s);
            tick();
            check("R4 push", status_o, {19'd0, 5'h15, 2'b00, v[3:0], 2'b00});
            check("R4 code", cause_o, {25'd0, 5'(s), 2'b00});
            wr(0, {19'd0, 5'h15, 2'b00, v});
            eret_req = 1;
            tick();
            check("R5 pop", status_o, {19'd0, 5'h15, 2'b00, v[5:4], v[5:4], v[3:2]});
            check("R5 code kept", cause_o, {25'd0, 5'(s), 2'b00});
        end
        wr(1, 0);

        // R6 pending capture and stickiness
        for (int i = 0; i < 5; i++) begin
            irq_i = 5'(1 << i);
            tick();
            irq_i = 0;
            tick(); tick();
            check("R6 sticky", cause_o, 32'(1 << (8 + i)));
            wr(1, 0);
            check("R6 cleared", cause_o, 0);
        end
        irq_i = 5'h04;
        wr(1, 0);
        check("R3 irq beats clear", cause_o, 32'h0000_0400);
        irq_i = 0;
        wr(1, 0);

        // R7 sweep of mask x pending x enable
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 32; p++) begin
                for (int e = 0; e < 2; e++) begin
                    wr(0, {19'd0, 5'(m), 7'd0, 1'(e)});
                    wr(1, {19'd0, 5'(p), 8'd0});
                    check("R7 take", {31'd0, irq_take},
                          {31'd0, (e == 1) && ((m & p) != 0)});
                end
            end
        end

        // R9 priority and dropped writes
        wr(1, 0);
        wr(0, {19'd0, 5'h03, 2'b00, 6'b10_01_11});
        exc_req = 1; eret_req = 1; exc_code = 5'd9;
        reg_wr = 1; reg_sel = 0; wr_data = 32'h0000_1F00;
        tick();
        check("R9 exc wins, write dropped", status_o, {19'd0, 5'h03, 2'b00, 6'b01_11_00});
        eret_req = 1; reg_wr = 1; reg_sel = 1; wr_data = 32'h0000_1F7C;
        tick();
        check("R9 cause write dropped", cause_o, {25'd0, 5'd9, 2'b00});
        check("R9 pop after", status_o, {19'd0, 5'h03, 2'b00, 6'b01_01_11});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule